// File: doc/BRIEF.md
# SATA Host Adapter Register File

This block is the software-visible register space of a SATA host adapter. A 32-bit word-access request port reaches one global register group and a parameterised number of per-port register groups. The block decodes each request address, applies each register's own access rule, and answers reads from a registered data stage one cycle after the request. The access rules are plain storage, read-only constants, write-one-to-clear, write-one-to-set, and masked or partly protected stores.

Hardware event inputs set per-port interrupt and error status bits. The block reduces each port's enabled interrupt status into a sticky global status vector, and drives a single interrupt output from that vector and a global enable bit. When software requests a global reset or a link reset of one port, the block reports it as a one-cycle pulse. The logic that acts on those pulses lies outside the block.

Top module: `hba_regfile`

## Requirements
- R1: After reset the global control word reads 0x8000_0000, all storage registers of every port read 0, `rd_valid` is low, `irq` is low and no reset pulse is high.
- R2: A read request accepted at a clock edge gives `rd_data` and a one-cycle `rd_valid` pulse in the following cycle. A write never raises `rd_valid`.
- R3: Global words 0 to 4 (byte addresses 0x00 to 0x10) are capability (`CAP_VAL`), control, global status, port-implemented mask (low `NPORTS` bits set) and version (`VS_VAL`). Every other address below the port base, and every address at or above the end of the port range, reads 0 and ignores writes. Capability, port mask and version ignore writes.
- R4: A control write with bit 0 set raises `host_reset_pulse` for one cycle and leaves the control word unchanged. Any other control write loads bits 1:0 from the data and forces bit 31 to 1. Bit 1 is the global interrupt enable.
- R5: Port p occupies 128 bytes from byte address 0x100 + p*0x80. Word 0 (list base low), word 1 (list base high), word 2 (receive area low) and word 3 (receive area high) are full 32-bit read/write.
- R6: Port interrupt status (word 4) bits are set by `port_is_evt` and cleared by writing ones. When a clear and an event hit the same bit in the same cycle, the bit ends up set.
- R7: A write to the port interrupt enable (word 5) stores only the bits of mask 0xFDC0_00FF.
- R8: A write to the port command word (word 6) keeps bits 15:8 (read-only status), forces bits 31:28 to 0 and takes every other bit from the data.
- R9: Word 8 reads 0x0000_007F, word 9 reads 0xFFFF_FFFF and word 10 reads 0x0000_0113 while that port's `dev_present` is high and 0 otherwise. All three ignore writes.
- R10: Word 11 (link control) stores every write. A write that changes bits 3:0 from 1 to 0 raises bit p of `port_reset_pulse` for one cycle.
- R11: Word 12 (error) is set by `port_serr_evt` and cleared by writing ones. Word 13 (active tags) and word 14 (issued commands) are write-one-to-set.
- R12: Global status bit p is set whenever (port p status AND port p enable) is nonzero, and is cleared by writing ones while that condition is false. `irq` is high exactly when control bit 1 is set and global status is nonzero.
- R13: Port words 7 and 15 to 31 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, held between reads |
| dev_present | input | NPORTS | Device attached, one bit per port |
| port_is_evt | input | NPORTS*32 | Interrupt status set events, 32 bits per port |
| port_serr_evt | input | NPORTS*32 | Error set events, 32 bits per port |
| irq | output | 1 | Interrupt request |
| host_reset_pulse | output | 1 | Global reset request pulse |
| port_reset_pulse | output | NPORTS | Per-port link reset request pulse |

## Verification
A request or event sampled at rising edge k changes the addressed register at k. Read data, reset pulses and port status are visible in the cycle after k. Global status and `irq` follow one cycle later, because global status is itself a register fed by the port pending terms. The bench drives inputs and samples outputs on falling edges. After an event it samples `irq` at the first falling edge, where it expects low, and again at the second, where it expects high. Every read result is taken at the falling edge that follows the request edge, and pulses are checked at that edge and again one cycle later.

// File: rtl/hba_pkg.sv
package hba_pkg;
  localparam int WORD_W = 32;

  // per-port word indices
  localparam logic [4:0] PW_LBASE_LO = 5'd0;
  localparam logic [4:0] PW_LBASE_HI = 5'd1;
  localparam logic [4:0] PW_RXA_LO   = 5'd2;
  localparam logic [4:0] PW_RXA_HI   = 5'd3;
  localparam logic [4:0] PW_ISTAT    = 5'd4;
  localparam logic [4:0] PW_IEN      = 5'd5;
  localparam logic [4:0] PW_CMD      = 5'd6;
  localparam logic [4:0] PW_TASKF    = 5'd8;
  localparam logic [4:0] PW_DSIG     = 5'd9;
  localparam logic [4:0] PW_LSTAT    = 5'd10;
  localparam logic [4:0] PW_LCTL     = 5'd11;
  localparam logic [4:0] PW_LERR     = 5'd12;
  localparam logic [4:0] PW_ACTV     = 5'd13;
  localparam logic [4:0] PW_ISSUE    = 5'd14;

  // global word indices
  localparam logic [5:0] GW_CAPS  = 6'd0;
  localparam logic [5:0] GW_CTRL  = 6'd1;
  localparam logic [5:0] GW_STAT  = 6'd2;
  localparam logic [5:0] GW_PMASK = 6'd3;
  localparam logic [5:0] GW_VER   = 6'd4;

  localparam logic [31:0] IEN_WMASK   = 32'hFDC0_00FF;
  localparam logic [31:0] CMD_RO_MASK = 32'h0000_FF00;
  localparam logic [31:0] CMD_ZERO_MASK = 32'hF000_0000;
  localparam logic [31:0] LSTAT_UP    = 32'h0000_0113;
  localparam logic [31:0] TASKF_VAL   = 32'h0000_007F;
  localparam logic [31:0] DSIG_VAL    = 32'hFFFF_FFFF;
  localparam logic [31:0] CTRL_RST_VAL = 32'h8000_0000;

  typedef struct packed {
    logic       glob_hit;
    logic       port_hit;
    logic [5:0] glob_word;
    logic [4:0] port_word;
  } dec_t;
endpackage

// File: rtl/hba_addr_decode.sv
module hba_addr_decode
  import hba_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NPORTS    = 4,
  parameter int PORT_BASE = 32'h100,
  parameter int PIDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec,
  output logic [PIDX_W-1:0] port_idx
);
  localparam int PORT_SPAN = 128;
  localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(PORT_BASE);
  localparam logic [ADDR_W:0] END_X  = (ADDR_W+1)'(PORT_BASE + NPORTS*PORT_SPAN);

  logic [ADDR_W:0] addr_x;
  logic [ADDR_W:0] off;
  logic            unused_bits;

  always_comb begin
    addr_x        = {1'b0, addr};
    off           = addr_x - BASE_X;
    dec.glob_hit  = (addr_x < BASE_X);
    dec.port_hit  = (addr_x >= BASE_X) && (addr_x < END_X);
    dec.glob_word = addr[7:2];
    dec.port_word = addr[6:2];
    port_idx      = off[7 +: PIDX_W];
  end

  assign unused_bits = ^{addr[1:0], off};
endmodule

// File: rtl/hba_port_regs.sv
module hba_port_regs
  import hba_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  word,
  input  logic [31:0] wdata,
  input  logic [31:0] is_evt,
  input  logic [31:0] serr_evt,
  input  logic        dev_present,
  output logic [31:0] rd_word,
  output logic        pend,
  output logic        reset_pulse
);
  logic [31:0] lb_lo_q, lb_hi_q, rx_lo_q, rx_hi_q;
  logic [31:0] is_q, ien_q, cmd_q, lctl_q, lerr_q, actv_q, issue_q;
  logic [31:0] is_nxt, ien_nxt, cmd_nxt, lerr_nxt, actv_nxt, issue_nxt;
  logic        we_lb_lo, we_lb_hi, we_rx_lo, we_rx_hi;
  logic        we_is, we_ien, we_cmd, we_lctl, we_lerr, we_actv, we_issue;
  logic        det_fall;
  logic        pulse_q;

  // next-state
  always_comb begin
    we_lb_lo = wr_en && (word == PW_LBASE_LO);
    we_lb_hi = wr_en && (word == PW_LBASE_HI);
    we_rx_lo = wr_en && (word == PW_RXA_LO);
    we_rx_hi = wr_en && (word == PW_RXA_HI);
    we_is    = wr_en && (word == PW_ISTAT);
    we_ien   = wr_en && (word == PW_IEN);
    we_cmd   = wr_en && (word == PW_CMD);
    we_lctl  = wr_en && (word == PW_LCTL);
    we_lerr  = wr_en && (word == PW_LERR);
    we_actv  = wr_en && (word == PW_ACTV);
    we_issue = wr_en && (word == PW_ISSUE);

    is_nxt    = (we_is ? (is_q & ~wdata) : is_q) | is_evt;
    lerr_nxt  = (we_lerr ? (lerr_q & ~wdata) : lerr_q) | serr_evt;
    ien_nxt   = wdata & IEN_WMASK;
    cmd_nxt   = (cmd_q & CMD_RO_MASK) | (wdata & ~(CMD_RO_MASK | CMD_ZERO_MASK));
    actv_nxt  = actv_q | wdata;
    issue_nxt = issue_q | wdata;
    det_fall  = we_lctl && (lctl_q[3:0] == 4'd1) && (wdata[3:0] == 4'd0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_lo_q <= '0; lb_hi_q <= '0; rx_lo_q <= '0; rx_hi_q <= '0;
      is_q    <= '0; ien_q   <= '0; cmd_q   <= '0; lctl_q  <= '0;
      lerr_q  <= '0; actv_q  <= '0; issue_q <= '0; pulse_q <= 1'b0;
    end else begin
      is_q    <= is_nxt;
      lerr_q  <= lerr_nxt;
      pulse_q <= det_fall;
      if (we_lb_lo) lb_lo_q <= wdata;
      if (we_lb_hi) lb_hi_q <= wdata;
      if (we_rx_lo) rx_lo_q <= wdata;
      if (we_rx_hi) rx_hi_q <= wdata;
      if (we_ien)   ien_q   <= ien_nxt;
      if (we_cmd)   cmd_q   <= cmd_nxt;
      if (we_lctl)  lctl_q  <= wdata;
      if (we_actv)  actv_q  <= actv_nxt;
      if (we_issue) issue_q <= issue_nxt;
    end
  end

  // read view
  always_comb begin
    case (word)
      PW_LBASE_LO: rd_word = lb_lo_q;
      PW_LBASE_HI: rd_word = lb_hi_q;
      PW_RXA_LO:   rd_word = rx_lo_q;
      PW_RXA_HI:   rd_word = rx_hi_q;
      PW_ISTAT:    rd_word = is_q;
      PW_IEN:      rd_word = ien_q;
      PW_CMD:      rd_word = cmd_q;
      PW_TASKF:    rd_word = TASKF_VAL;
      PW_DSIG:     rd_word = DSIG_VAL;
      PW_LSTAT:    rd_word = dev_present ? LSTAT_UP : 32'h0;
      PW_LCTL:     rd_word = lctl_q;
      PW_LERR:     rd_word = lerr_q;
      PW_ACTV:     rd_word = actv_q;
      PW_ISSUE:    rd_word = issue_q;
      default:     rd_word = 32'h0;
    endcase
  end

  assign pend        = |(is_q & ien_q);
  assign reset_pulse = pulse_q;
endmodule

// File: rtl/hba_glob_regs.sv
module hba_glob_regs
  import hba_pkg::*;
#(
  parameter int          NPORTS  = 4,
  parameter logic [31:0] CAP_VAL = 32'h4000_0003,
  parameter logic [31:0] VS_VAL  = 32'h0001_0300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [5:0]        word,
  input  logic [31:0]       wdata,
  input  logic [NPORTS-1:0] port_pend,
  output logic [31:0]       rd_word,
  output logic              irq,
  output logic              host_reset_pulse
);
  localparam logic [31:0] PMASK = 32'((64'd1 << NPORTS) - 64'd1);

  logic [31:0]       ctrl_q, ctrl_nxt;
  logic [NPORTS-1:0] gstat_q, gstat_nxt;
  logic              we_ctrl, we_gstat, hreset_req, pulse_q;
  logic              unused_bits;

  always_comb begin
    we_ctrl    = wr_en && (word == GW_CTRL);
    we_gstat   = wr_en && (word == GW_STAT);
    hreset_req = we_ctrl && wdata[0];
    ctrl_nxt   = CTRL_RST_VAL | {30'h0, wdata[1:0]};
    gstat_nxt  = (we_gstat ? (gstat_q & ~wdata[NPORTS-1:0]) : gstat_q) | port_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST_VAL;
      gstat_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      gstat_q <= gstat_nxt;
      pulse_q <= hreset_req;
      if (we_ctrl && !hreset_req) ctrl_q <= ctrl_nxt;
    end
  end

  always_comb begin
    case (word)
      GW_CAPS:  rd_word = CAP_VAL;
      GW_CTRL:  rd_word = ctrl_q;
      GW_STAT:  rd_word = 32'(gstat_q);
      GW_PMASK: rd_word = PMASK;
      GW_VER:   rd_word = VS_VAL;
      default:  rd_word = 32'h0;
    endcase
  end

  assign irq              = ctrl_q[1] && (|gstat_q);
  assign host_reset_pulse = pulse_q;
  assign unused_bits      = ^wdata;
endmodule

// File: rtl/hba_regfile.sv
module hba_regfile
  import hba_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          NPORTS    = 4,
  parameter int          PORT_BASE = 32'h100,
  parameter logic [31:0] CAP_VAL   = 32'h4000_0003,
  parameter logic [31:0] VS_VAL    = 32'h0001_0300
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [31:0]            req_wdata,
  output logic                   rd_valid,
  output logic [31:0]            rd_data,
  input  logic [NPORTS-1:0]      dev_present,
  input  logic [NPORTS*32-1:0]   port_is_evt,
  input  logic [NPORTS*32-1:0]   port_serr_evt,
  output logic                   irq,
  output logic                   host_reset_pulse,
  output logic [NPORTS-1:0]      port_reset_pulse
);
  localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  dec_t              dec;
  logic [PIDX_W-1:0] pidx;
  logic [31:0]       port_rd [NPORTS];
  logic [NPORTS-1:0] port_pend;
  logic [31:0]       glob_rd;
  logic [31:0]       rd_nxt;
  logic              rd_en, wr_en;
  logic              rdv_q;
  logic [31:0]       rdd_q;

  assign rd_en = req_valid && !req_write;
  assign wr_en = req_valid && req_write;

  hba_addr_decode #(
    .ADDR_W(ADDR_W), .NPORTS(NPORTS), .PORT_BASE(PORT_BASE), .PIDX_W(PIDX_W)
  ) u_dec (
    .addr(req_addr), .dec(dec), .port_idx(pidx)
  );

  hba_glob_regs #(
    .NPORTS(NPORTS), .CAP_VAL(CAP_VAL), .VS_VAL(VS_VAL)
  ) u_glob (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && dec.glob_hit),
    .word(dec.glob_word), .wdata(req_wdata),
    .port_pend(port_pend),
    .rd_word(glob_rd), .irq(irq), .host_reset_pulse(host_reset_pulse)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    hba_port_regs u_port (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en && dec.port_hit && (pidx == PIDX_W'(p))),
      .word(dec.port_word), .wdata(req_wdata),
      .is_evt(port_is_evt[p*32 +: 32]),
      .serr_evt(port_serr_evt[p*32 +: 32]),
      .dev_present(dev_present[p]),
      .rd_word(port_rd[p]), .pend(port_pend[p]),
      .reset_pulse(port_reset_pulse[p])
    );
  end

  always_comb begin
    if (dec.glob_hit)      rd_nxt = glob_rd;
    else if (dec.port_hit) rd_nxt = port_rd[pidx];
    else                   rd_nxt = 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q <= 1'b0;
      rdd_q <= '0;
    end else begin
      rdv_q <= rd_en;
      if (rd_en) rdd_q <= rd_nxt;
    end
  end

  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;
endmodule

// File: rtl/hba_regfile_chk.sv
module hba_regfile_chk #(
  parameter int ADDR_W    = 12,
  parameter int NPORTS    = 4,
  parameter int PORT_BASE = 32'h100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic              host_reset_pulse,
  input logic [NPORTS-1:0] port_reset_pulse
);
  localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(PORT_BASE);
  localparam logic [ADDR_W:0] END_X  = (ADDR_W+1)'(PORT_BASE + NPORTS*128);

  logic            past_ok;
  logic [ADDR_W:0] ax;
  logic            unmapped, ctrl_rst_wr, lctl_zero_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_comb begin
    ax           = {1'b0, req_addr};
    unmapped     = (ax >= END_X) || ((ax < BASE_X) && (req_addr[7:2] > 6'd4));
    ctrl_rst_wr  = req_valid && req_write && (ax == (ADDR_W+1)'(4)) && req_wdata[0];
    lctl_zero_wr = req_valid && req_write && (ax >= BASE_X) && (ax < END_X) &&
                   (req_addr[6:2] == 5'd11) && (req_wdata[3:0] == 4'd0);
  end

  p_rd_valid_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (rd_valid == $past(req_valid && !req_write)))
    else $error("rd_valid timing");

  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rd_valid && $past(unmapped)) |-> (rd_data == 32'h0))
    else $error("unmapped read nonzero");

  p_host_reset_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (host_reset_pulse == $past(ctrl_rst_wr)))
    else $error("host reset pulse mismatch");

  p_port_reset_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (|port_reset_pulse)) |-> $past(lctl_zero_wr))
    else $error("port reset without link control write");

  p_port_reset_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_reset_pulse))
    else $error("several port reset pulses");
endmodule

bind hba_regfile hba_regfile_chk #(
  .ADDR_W(ADDR_W), .NPORTS(NPORTS), .PORT_BASE(PORT_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
  .rd_data(rd_data), .host_reset_pulse(host_reset_pulse),
  .port_reset_pulse(port_reset_pulse)
);

// File: tb/hba_regfile_bench.sv
module hba_regfile_bench;
  localparam int          NP   = 4;
  localparam logic [31:0] CAPV = 32'h4002_1F03;
  localparam logic [31:0] VSV  = 32'h0001_0300;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0, req_write = 1'b0;
  logic [11:0]     req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic            rd_valid;
  logic [31:0]     rd_data;
  logic [NP-1:0]   dev_present = '0;
  logic [NP*32-1:0] is_evt = '0, serr_evt = '0;
  logic            irq, host_reset_pulse;
  logic [NP-1:0]   port_reset_pulse;

  int checks = 0, errors = 0;
  logic [NP-1:0] last_prst;
  logic          last_hrst;
  logic [31:0]   rv;

  always #5 clk = ~clk;

  hba_regfile #(.ADDR_W(12), .NPORTS(NP), .PORT_BASE(32'h100),
                .CAP_VAL(CAPV), .VS_VAL(VSV)) u_hba_regfile (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .dev_present(dev_present), .port_is_evt(is_evt),
    .port_serr_evt(serr_evt), .irq(irq), .host_reset_pulse(host_reset_pulse),
    .port_reset_pulse(port_reset_pulse)
  );

  function automatic logic [11:0] pa(input int p, input int w);
    return 12'(32'h100 + p*128 + w*4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    last_prst = port_reset_pulse;
    last_hrst = host_reset_pulse;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rd_valid after read", 32'(rd_valid), 32'h1);
    d = rd_data;
  endtask

  task automatic t_reset;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pulses", 32'({host_reset_pulse, port_reset_pulse}), 0);
    chk("R2 rd_valid idle", 32'(rd_valid), 0);
    rd(12'h004, rv); chk("R1 control", rv, 32'h8000_0000);
    rd(pa(0, 0), rv); chk("R1 port0 list base", rv, 0);
    rd(pa(3, 14), rv); chk("R1 port3 issue", rv, 0);
    @(negedge clk);
    chk("R2 rd_valid one cycle", 32'(rd_valid), 0);
  endtask

  task automatic t_glob_map;
    rd(12'h000, rv); chk("R3 caps", rv, CAPV);
    rd(12'h00C, rv); chk("R3 port mask", rv, 32'h0000_000F);
    rd(12'h010, rv); chk("R3 version", rv, VSV);
    wr(12'h000, 32'h0); wr(12'h00C, 32'h0); wr(12'h010, 32'h0);
    rd(12'h000, rv); chk("R3 caps ro", rv, CAPV);
    rd(12'h00C, rv); chk("R3 mask ro", rv, 32'h0000_000F);
    rd(12'h010, rv); chk("R3 version ro", rv, VSV);
    wr(12'h018, 32'hFFFF_FFFF);
    rd(12'h018, rv); chk("R3 unused global word", rv, 0);
    wr(12'h300, 32'hFFFF_FFFF);
    rd(12'h300, rv); chk("R3 past port range", rv, 0);
    rd(12'hFFC, rv); chk("R3 top address", rv, 0);
  endtask

  task automatic t_ctrl;
    wr(12'h004, 32'h0000_0002);
    chk("R4 no pulse on plain write", 32'(last_hrst), 0);
    rd(12'h004, rv); chk("R4 control load", rv, 32'h8000_0002);
    wr(12'h004, 32'h0000_0001);
    chk("R4 reset pulse", 32'(last_hrst), 1);
    @(negedge clk);
    chk("R4 pulse one cycle", 32'(host_reset_pulse), 0);
    rd(12'h004, rv); chk("R4 control kept", rv, 32'h8000_0002);
  endtask

  task automatic t_ptrs;
    wr(pa(2, 0), 32'hDEAD_BEEF);
    wr(pa(1, 3), 32'h1234_5678);
    wr(pa(3, 2), 32'hCAFE_F00D);
    rd(pa(2, 0), rv); chk("R5 port2 word0", rv, 32'hDEAD_BEEF);
    rd(pa(1, 3), rv); chk("R5 port1 word3", rv, 32'h1234_5678);
    rd(pa(3, 2), rv); chk("R5 port3 word2", rv, 32'hCAFE_F00D);
    rd(pa(1, 0), rv); chk("R5 no alias", rv, 0);
  endtask

  task automatic t_ien;
    wr(pa(0, 5), 32'hFFFF_FFFF);
    rd(pa(0, 5), rv); chk("R7 enable mask", rv, 32'hFDC0_00FF);
    wr(pa(0, 5), 32'h0);
    rd(pa(0, 5), rv); chk("R7 enable clear", rv, 0);
  endtask

  task automatic t_cmd;
    wr(pa(1, 6), 32'hFFFF_FFFF);
    rd(pa(1, 6), rv); chk("R8 command mask", rv, 32'h0FFF_00FF);
    wr(pa(1, 6), 32'h0000_0011);
    rd(pa(1, 6), rv); chk("R8 command rewrite", rv, 32'h0000_0011);
  endtask

  task automatic t_fixed;
    dev_present = 4'b0010;
    wr(pa(1, 8), 32'h0); wr(pa(1, 9), 32'h0); wr(pa(1, 10), 32'h0);
    rd(pa(1, 8), rv);  chk("R9 task file", rv, 32'h0000_007F);
    rd(pa(1, 9), rv);  chk("R9 signature", rv, 32'hFFFF_FFFF);
    rd(pa(1, 10), rv); chk("R9 link up", rv, 32'h0000_0113);
    rd(pa(0, 10), rv); chk("R9 no device", rv, 0);
  endtask

  task automatic t_lctl;
    wr(pa(3, 11), 32'h0000_0301);
    chk("R10 no pulse on set", 32'(last_prst), 0);
    rd(pa(3, 11), rv); chk("R10 stored", rv, 32'h0000_0301);
    wr(pa(3, 11), 32'h0000_0300);
    chk("R10 pulse port3", 32'(last_prst), 32'h8);
    @(negedge clk);
    chk("R10 pulse one cycle", 32'(port_reset_pulse), 0);
    rd(pa(3, 11), rv); chk("R10 new value", rv, 32'h0000_0300);
    wr(pa(3, 11), 32'h0000_0300);
    chk("R10 zero to zero", 32'(last_prst), 0);
    wr(pa(3, 11), 32'h2); wr(pa(3, 11), 32'h0);
    chk("R10 two to zero", 32'(last_prst), 0);
  endtask

  task automatic t_err_set;
    @(negedge clk); serr_evt[32 +: 32] = 32'h0000_0404;
    @(negedge clk); serr_evt = '0;
    rd(pa(1, 12), rv); chk("R11 error set", rv, 32'h0000_0404);
    wr(pa(1, 12), 32'h0000_0004);
    rd(pa(1, 12), rv); chk("R11 error w1c", rv, 32'h0000_0400);
    wr(pa(2, 13), 32'h1); wr(pa(2, 13), 32'h4);
    rd(pa(2, 13), rv); chk("R11 active set", rv, 32'h5);
    wr(pa(2, 14), 32'h80); wr(pa(2, 14), 32'h0);
    rd(pa(2, 14), rv); chk("R11 issue set", rv, 32'h80);
  endtask

  task automatic t_istat;
    @(negedge clk); is_evt[0 +: 32] = 32'h8;
    @(negedge clk); is_evt = '0;
    rd(pa(0, 4), rv); chk("R6 status set", rv, 32'h8);
    wr(pa(0, 4), 32'h8);
    rd(pa(0, 4), rv); chk("R6 status w1c", rv, 0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = pa(0, 4); req_wdata = 32'h20;
    is_evt[0 +: 32] = 32'h20;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; is_evt = '0;
    rd(pa(0, 4), rv); chk("R6 set beats clear", rv, 32'h20);
    chk("R12 disabled source no irq", 32'(irq), 0);
    rd(12'h008, rv); chk("R12 disabled source no global", rv, 0);
    wr(pa(0, 4), 32'hFFFF_FFFF);
  endtask

  task automatic t_irq;
    wr(12'h004, 32'h2);
    wr(pa(2, 5), 32'h1);
    @(negedge clk); is_evt[64 +: 32] = 32'h1;
    @(negedge clk); is_evt = '0;
    chk("R12 irq not yet", 32'(irq), 0);
    @(negedge clk);
    chk("R12 irq raised", 32'(irq), 1);
    rd(12'h008, rv); chk("R12 global status", rv, 32'h4);
    wr(12'h008, 32'h4);
    rd(12'h008, rv); chk("R12 reasserts while pending", rv, 32'h4);
    wr(pa(2, 4), 32'h1);
    rd(pa(2, 4), rv); chk("R6 port2 cleared", rv, 0);
    rd(12'h008, rv); chk("R12 global sticky", rv, 32'h4);
    chk("R12 irq sticky", 32'(irq), 1);
    wr(12'h004, 32'h0);
    chk("R12 irq masked", 32'(irq), 0);
    wr(12'h004, 32'h2);
    chk("R12 irq unmasked", 32'(irq), 1);
    wr(12'h008, 32'h4);
    chk("R12 irq after clear", 32'(irq), 0);
    rd(12'h008, rv); chk("R12 global cleared", rv, 0);
  endtask

  task automatic t_reserved;
    wr(pa(0, 7), 32'hFFFF_FFFF);
    wr(pa(0, 20), 32'hFFFF_FFFF);
    wr(pa(0, 15), 32'hFFFF_FFFF);
    rd(pa(0, 7), rv);  chk("R13 word7", rv, 0);
    rd(pa(0, 20), rv); chk("R13 word20", rv, 0);
    rd(pa(0, 15), rv); chk("R13 word15", rv, 0);
    rd(pa(0, 31), rv); chk("R13 word31", rv, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_glob_map;
    t_ctrl;
    t_ptrs;
    t_ien;
    t_cmd;
    t_fixed;
    t_lctl;
    t_err_set;
    t_istat;
    t_irq;
    t_reserved;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired got %h exp %h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule